// File: doc/BRIEF.md
# DRAM Row-Buffer Page Policy Engine

This block sits beside a DRAM command scheduler and decides, per column access, whether the bank's row should be closed with an auto-precharge as soon as the access finishes. The scheduler presents the access with its bank and row, the bank's current open row and whether the bank holds an open row at all. It also gives two counts taken from its queue: requests that hit the open row of that bank, and requests aimed at other rows of the same bank. The engine returns, in the same cycle, whether the access needs an activate, how many accesses the open row has served so far including this one, and the auto-precharge flag.

A 2-bit policy select picks the page management rule. Plain open keeps rows open. Open-adaptive closes a row once nothing queued still wants it and another row of the bank is waiting. Close-adaptive closes a row unless more queued work hits it. Closed precharges after every access. Under the two open rules, a per-bank access counter forces a close when it reaches a parameterised limit, so that a stream of row hits cannot starve requests to other rows. Open-adaptive (encoding 1) is the intended default setting for the select.

Top module: `page_policy_engine`

## Requirements
- R1: After reset every per-bank counter is zero, so the first row-hit access to any bank reports a count of 1; while acc_valid_i is low, act_o, auto_pre_o and acc_cnt_o are all 0.
- R2: act_o is 1 for a valid access when bank_open_i is 0 or open_row_i differs from acc_row_i, and 0 otherwise.
- R3: acc_cnt_o is 1 for an access with act_o high; otherwise it is the bank's stored count plus one, saturating at 2^CNT_W-1, where CNT_W = clog2(MAX_ACC+1).
- R4: The stored count of a bank becomes 0 after an access of that bank with auto_pre_o high, and becomes acc_cnt_o after an access with auto_pre_o low.
- R5: With policy_i = 0 (open), auto_pre_o is 1 exactly when acc_cnt_o >= MAX_ACC.
- R6: With policy_i = 1 (open-adaptive), auto_pre_o is 1 when acc_cnt_o >= MAX_ACC, or when q_hit_i is 0 and q_miss_i is nonzero; otherwise 0.
- R7: With policy_i = 2 (close-adaptive), auto_pre_o is 1 exactly when q_hit_i is 0, regardless of the count.
- R8: With policy_i = 3 (closed), auto_pre_o is 1 for every valid access.
- R9: An access to one bank leaves the stored count of every other bank unchanged.
- R10: A cycle with acc_valid_i low leaves all stored counts unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| policy_i | input | 2 | Page policy: 0 open, 1 open-adaptive, 2 close-adaptive, 3 closed |
| acc_valid_i | input | 1 | Column access presented this cycle |
| acc_bank_i | input | BANK_W | Bank of the access |
| acc_row_i | input | ROW_W | Row of the access |
| bank_open_i | input | 1 | The bank currently holds an open row |
| open_row_i | input | ROW_W | Open row of the accessed bank |
| q_hit_i | input | QCNT_W | Queued requests hitting the open row of the bank |
| q_miss_i | input | QCNT_W | Queued requests to other rows of the bank |
| act_o | output | 1 | Access requires an activate |
| auto_pre_o | output | 1 | Close the row with auto-precharge after this access |
| acc_cnt_o | output | CNT_W | Accesses served by the open row, this one included |

## Verification
The hardest condition to reach is a bank whose counter saturates: the open rules close the row at the limit, so only close-adaptive with queued hits lets the count climb to its maximum, and a directed run of row hits with q_hit_i held nonzero drives it there. The limit-forced close is reached by directed hit streams under open and open-adaptive with queued hits present, and then a further hit on the same row shows the cleared count. Random traffic over a small row set and few banks interleaves hits, misses and closed banks so that per-bank counter isolation is exercised under every policy.

// File: rtl/ppe_pkg.sv
package ppe_pkg;
  typedef enum logic [1:0] {
    POL_OPEN      = 2'd0,
    POL_OPEN_ADPT = 2'd1,
    POL_CLOS_ADPT = 2'd2,
    POL_CLOSED    = 2'd3
  } page_pol_e;
endpackage

// File: rtl/ppe_bank_ctr.sv
module ppe_bank_ctr #(
  parameter int CNT_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [CNT_W-1:0] d_i,
  output logic [CNT_W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (we_i) q_o <= d_i;
  end
endmodule

// File: rtl/ppe_decide.sv
module ppe_decide
  import ppe_pkg::*;
#(
  parameter int CNT_W   = 3,
  parameter int QCNT_W  = 4,
  parameter int MAX_ACC = 4
) (
  input  logic [1:0]        policy_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [QCNT_W-1:0] q_hit_i,
  input  logic [QCNT_W-1:0] q_miss_i,
  output logic              ap_o
);
  logic at_limit;
  assign at_limit = (32'(cnt_i) >= 32'(MAX_ACC));

  always_comb begin
    unique case (page_pol_e'(policy_i))
      POL_OPEN:      ap_o = at_limit;
      POL_OPEN_ADPT: ap_o = at_limit || ((q_hit_i == '0) && (q_miss_i != '0));
      POL_CLOS_ADPT: ap_o = (q_hit_i == '0);
      default:       ap_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/page_policy_engine.sv
module page_policy_engine
  import ppe_pkg::*;
#(
  parameter int NUM_BANKS = 8,
  parameter int ROW_W     = 14,
  parameter int QCNT_W    = 4,
  parameter int MAX_ACC   = 4,
  localparam int BANK_W   = $clog2(NUM_BANKS),
  localparam int CNT_W    = $clog2(MAX_ACC + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        policy_i,
  input  logic              acc_valid_i,
  input  logic [BANK_W-1:0] acc_bank_i,
  input  logic [ROW_W-1:0]  acc_row_i,
  input  logic              bank_open_i,
  input  logic [ROW_W-1:0]  open_row_i,
  input  logic [QCNT_W-1:0] q_hit_i,
  input  logic [QCNT_W-1:0] q_miss_i,
  output logic              act_o,
  output logic              auto_pre_o,
  output logic [CNT_W-1:0]  acc_cnt_o
);
  localparam logic [CNT_W-1:0] CNT_SAT = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q [NUM_BANKS];
  logic [CNT_W-1:0] cur_cnt, nxt_cnt, store_cnt;
  logic             need_act, ap;

  assign need_act = !bank_open_i || (open_row_i != acc_row_i);
  assign cur_cnt  = cnt_q[acc_bank_i];
  // activate restarts the count; saturate otherwise
  assign nxt_cnt  = need_act            ? CNT_W'(1) :
                    (cur_cnt == CNT_SAT) ? cur_cnt   : cur_cnt + CNT_W'(1);
  assign store_cnt = ap ? '0 : nxt_cnt;

  ppe_decide #(
    .CNT_W(CNT_W), .QCNT_W(QCNT_W), .MAX_ACC(MAX_ACC)
  ) u_decide (
    .policy_i (policy_i),
    .cnt_i    (nxt_cnt),
    .q_hit_i  (q_hit_i),
    .q_miss_i (q_miss_i),
    .ap_o     (ap)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    ppe_bank_ctr #(.CNT_W(CNT_W)) u_ctr (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .we_i   (acc_valid_i && (acc_bank_i == BANK_W'(b))),
      .d_i    (store_cnt),
      .q_o    (cnt_q[b])
    );
  end

  assign act_o      = acc_valid_i && need_act;
  assign auto_pre_o = acc_valid_i && ap;
  assign acc_cnt_o  = acc_valid_i ? nxt_cnt : '0;
endmodule

// File: rtl/page_policy_engine_chk.sv
module page_policy_engine_chk #(
  parameter int NUM_BANKS = 8,
  parameter int ROW_W     = 14,
  parameter int QCNT_W    = 4,
  parameter int MAX_ACC   = 4,
  localparam int BANK_W   = $clog2(NUM_BANKS),
  localparam int CNT_W    = $clog2(MAX_ACC + 1)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [1:0]        policy_i,
  input logic              acc_valid_i,
  input logic [BANK_W-1:0] acc_bank_i,
  input logic [QCNT_W-1:0] q_hit_i,
  input logic              act_o,
  input logic              auto_pre_o,
  input logic [CNT_W-1:0]  acc_cnt_o
);
  localparam logic [CNT_W-1:0] CNT_SAT = {CNT_W{1'b1}};

  // R1
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc_valid_i |-> (!act_o && !auto_pre_o && acc_cnt_o == '0));

  // R3
  act_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_i && act_o) |-> (acc_cnt_o == CNT_W'(1)));

  // R3
  hit_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_i && !act_o) |-> (acc_cnt_o != '0));

  // R4
  cnt_chain_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_i && !act_o && $past(acc_valid_i) && $past(acc_bank_i) == acc_bank_i
     && !$past(auto_pre_o) && $past(acc_cnt_o) != CNT_SAT)
    |-> (acc_cnt_o == CNT_W'($past(acc_cnt_o) + CNT_W'(1))));

  // R5
  open_limit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_i && policy_i == 2'd0) |-> (auto_pre_o == (32'(acc_cnt_o) >= 32'(MAX_ACC))));

  // R7
  clos_adpt_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_i && policy_i == 2'd2) |-> (auto_pre_o == (q_hit_i == '0)));

  // R8
  closed_always_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_i && policy_i == 2'd3) |-> auto_pre_o);
endmodule

bind page_policy_engine page_policy_engine_chk #(
  .NUM_BANKS(NUM_BANKS), .ROW_W(ROW_W), .QCNT_W(QCNT_W), .MAX_ACC(MAX_ACC)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .policy_i    (policy_i),
  .acc_valid_i (acc_valid_i),
  .acc_bank_i  (acc_bank_i),
  .q_hit_i     (q_hit_i),
  .act_o       (act_o),
  .auto_pre_o  (auto_pre_o),
  .acc_cnt_o   (acc_cnt_o)
);

// File: tb/tb_page_policy_engine.sv
`timescale 1ns/1ps
module tb_page_policy_engine;
  localparam int NB = 8, RW = 14, QW = 4, MAXA = 4;
  localparam int BW = $clog2(NB);
  localparam int CW = $clog2(MAXA + 1);
  localparam int SAT = (1 << CW) - 1;

  logic          clk = 1'b0, rst_n = 1'b0;
  logic [1:0]    pol = '0;
  logic          vld = 1'b0;
  logic [BW-1:0] bank = '0;
  logic [RW-1:0] row = '0, orow = '0;
  logic          bopen = 1'b0;
  logic [QW-1:0] qh = '0, qm = '0;
  logic          act, ap;
  logic [CW-1:0] cnt;

  int checks = 0, errors = 0;
  int mcnt [NB];
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  page_policy_engine #(.NUM_BANKS(NB), .ROW_W(RW), .QCNT_W(QW), .MAX_ACC(MAXA)) dut (
    .clk_i(clk), .rst_ni(rst_n), .policy_i(pol), .acc_valid_i(vld), .acc_bank_i(bank),
    .acc_row_i(row), .bank_open_i(bopen), .open_row_i(orow), .q_hit_i(qh), .q_miss_i(qm),
    .act_o(act), .auto_pre_o(ap), .acc_cnt_o(cnt));

  function automatic bit e_act(bit o, int r, int orw);
    return !o || (r != orw);
  endfunction

  function automatic int e_cnt(bit a, int prev);
    if (a) return 1;
    return (prev == SAT) ? prev : prev + 1;
  endfunction

  function automatic bit e_ap(int p, int c, int h, int m);
    case (p)
      0: return c >= MAXA;
      1: return (c >= MAXA) || (h == 0 && m != 0);
      2: return h == 0;
      default: return 1'b1;
    endcase
  endfunction

  task automatic chk(string tag, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, got, exp);
    end
  endtask

  // drive at negedge, check after settle, update model; posedge commits
  task automatic access(int p, int b, int r, bit o, int orw, int h, int m, string tag);
    bit ea, eap; int ec;
    @(negedge clk);
    pol = 2'(p); vld = 1'b1; bank = BW'(b); row = RW'(r); bopen = o; orow = RW'(orw);
    qh = QW'(h); qm = QW'(m);
    #1;
    ea  = e_act(o, r, orw);
    ec  = e_cnt(ea, mcnt[b]);
    eap = e_ap(p, ec, h, m);
    chk({"R2 act ", tag}, int'(act), int'(ea));
    chk({"R3 cnt ", tag}, int'(cnt), ec);
    chk({"R5-8 ap ", tag}, int'(ap), int'(eap));
    mcnt[b] = eap ? 0 : ec;
  endtask

  task automatic idle_cycle();
    @(negedge clk);
    vld = 1'b0; bank = BW'($urandom_range(NB - 1)); qh = QW'($urandom); qm = QW'($urandom);
    #1;
    chk("R1 idle act", int'(act), 0);
    chk("R1 idle ap", int'(ap), 0);
    chk("R1 idle cnt", int'(cnt), 0);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < NB; i++) mcnt[i] = 0;
    repeat (3) @(negedge clk);
    chk("R1 reset act", int'(act), 0);
    chk("R1 reset cnt", int'(cnt), 0);
    rst_n = 1'b1;

    // R1: first hit on each bank reports 1
    for (int b = 0; b < NB; b++) access(2, b, 7, 1, 7, 1, 0, "R1 first hit");

    // R5: open policy limit forces close, then R4 cleared count
    access(0, 0, 5, 1, 5, 3, 2, "R5 open");
    for (int k = 0; k < MAXA + 2; k++) access(0, 0, 5, 1, 5, 3, 2, "R5 open run");
    // R6: limit with queued hits, and early close on no-hit + miss
    access(1, 1, 9, 1, 9, 2, 0, "R6 adapt");
    for (int k = 0; k < MAXA; k++) access(1, 1, 9, 1, 9, 2, 1, "R6 limit");
    access(1, 1, 9, 1, 9, 0, 3, "R6 early close");
    access(1, 1, 9, 1, 9, 0, 0, "R6 keep no miss");
    // R7/R3: close-adaptive saturation
    for (int k = 0; k < SAT + 3; k++) access(2, 2, 4, 1, 4, 1, 5, "R3 R7 saturate");
    access(2, 2, 4, 1, 4, 0, 0, "R7 close no hit");
    // R8
    access(3, 3, 1, 0, 0, 4, 0, "R8 closed bank");
    access(3, 3, 1, 1, 1, 4, 0, "R8 closed hit");
    // R9: interleaved banks
    access(2, 4, 2, 1, 2, 1, 0, "R9 b4");
    access(2, 5, 2, 1, 2, 1, 0, "R9 b5");
    access(2, 5, 2, 1, 2, 1, 0, "R9 b5");
    access(2, 4, 2, 1, 2, 1, 0, "R9 b4 resumes");
    // R10: idle cycles keep counts
    repeat (4) idle_cycle();
    access(2, 4, 2, 1, 2, 1, 0, "R10 b4 after idle");

    for (int n = 0; n < 3000; n++) begin
      if ($urandom_range(9) == 0) idle_cycle();
      else access($urandom_range(3), $urandom_range(NB - 1), $urandom_range(3),
                  bit'($urandom_range(5) != 0), $urandom_range(3),
                  $urandom_range(2), $urandom_range(2), "rand");
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule